// File: doc/BRIEF.md
# Code/Data Cache Way-Mask Selector

This block keeps a bank of last-level-cache capacity masks and a one-bit mode control. Software reaches both through a register port with an address, a 64-bit write value and a combinational read value. A separate lookup port takes a class-of-service number and a code/data flag. It returns the way mask that limits which cache ways the access may fill.

With the mode bit clear, each class owns exactly one mask register. With the mode bit set, the same registers are indexed in pairs. Class c then takes its data mask from register 2c and its code mask from register 2c+1, so only half as many classes remain usable. Before setting the mode bit, software is expected to place all threads in class 0 with full masks, so that the change of indexing does not shrink anyone's allocation. Writes are checked: a mask must be a non-empty, unbroken run of ones that fits the mask width.

Top module: `cdp_mask_select`

## Requirements
- R1: After reset, every one of the 16 masks reads 0xFFFFF (20 ones) and the mode bit reads 0.
- R2: The mode bit is bit 0 of address 0xC81. A write there stores wdata[0] and never flags an error. A read returns the mode bit in bit 0 and zeros in bits 63:1.
- R3: Mask register i (0..15) is at address 0xC90+i. A read returns its 20-bit value in bits 19:0 and zeros above.
- R4: With the mode bit 0, class c (0..15) gets mask register c for both code and data accesses, and lk_bad is 0.
- R5: With the mode bit 1 and class c below 8, a data access (lk_code=0) gets register 2c and a code access (lk_code=1) gets register 2c+1, with lk_bad 0.
- R6: With the mode bit 1 and class c of 8 or more, lk_bad is 1 and the result is register 0 for data or register 1 for code.
- R7: A mask write is rejected if the value is zero, if its set bits are not one contiguous run, or if any bit above bit 19 is set. A rejected write raises err and leaves the register unchanged.
- R8: A read or write to any address other than 0xC81 and 0xC90..0xC9F returns rdata 0, raises err and changes no state.
- R9: The lookup is combinational from the stored state. A write accepted at a clock edge changes the lookup result right after that edge, and not before it.
- R10: err is 0 when neither rd_en nor wr_en is high, and it is 0 for every legal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 32 | Register address |
| wdata | input | 64 | Write value |
| rdata | output | 64 | Read value, combinational |
| err | output | 1 | Access rejected or address unmapped |
| lk_cls | input | 4 | Class-of-service number for lookup |
| lk_code | input | 1 | 1 = code fetch, 0 = data access |
| lk_mask | output | 20 | Selected way mask |
| lk_bad | output | 1 | Class out of range in paired mode |

## Verification
The hardest case to reach from the ports is a write that lands in the same cycle that the lookup reads the register being written. The bench holds a fixed class on the lookup port and issues the write. It checks the old mask before the edge and the new mask just after it. The second hard case is paired mode with classes at or above half the register count. The bench programs every register with a mask of a different width, so the fallback to register 0 or 1 shows up as a specific value in the vector table. Rejected writes are followed by read-back, so a change in stored state can be seen at the ports.

// File: rtl/cdp_pkg.sv
// Package: address map constants shared by the way-mask selector.
// Assumes a 32-bit register address space.
package cdp_pkg;
    localparam logic [31:0] CFG_ADDR  = 32'h0000_0C81;
    localparam logic [31:0] MASK_BASE = 32'h0000_0C90;
endpackage

// File: rtl/cdp_addr_decode.sv
// Address decode: classifies a register address as mode control, mask
// register (with its index) or unmapped. Assumes NUM_MASKS is a power of two.
module cdp_addr_decode #(
    parameter int ADDR_W    = 32,
    parameter int NUM_MASKS = 16,
    localparam int IDX_W    = $clog2(NUM_MASKS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_cfg_o,
    output logic              hit_mask_o,
    output logic [IDX_W-1:0]  idx_o
);
    import cdp_pkg::*;

    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = BASE_A + ADDR_W'(NUM_MASKS - 1);

    // Range compare for the two mapped regions.
    always_comb begin
        hit_cfg_o  = (addr_i == CFG_A);
        hit_mask_o = (addr_i >= BASE_A) && (addr_i <= LAST_A);
        idx_o      = IDX_W'(addr_i - BASE_A);
    end
endmodule

// File: rtl/cdp_mask_check.sv
// Mask shape check: accepts a write value only if it is a nonzero run of
// contiguous ones that lies entirely within the low MASK_W bits.
module cdp_mask_check #(
    parameter int DATA_W = 64,
    parameter int MASK_W = 20
) (
    input  logic [DATA_W-1:0] value_i,
    output logic              ok_o
);
    logic [MASK_W-1:0] low;
    logic [MASK_W-1:0] filled;
    logic [MASK_W:0]   ext;
    logic              high_clear;

    // Fill the zeros below the lowest set bit, then test that the result is 2^k-1.
    always_comb begin
        low        = value_i[MASK_W-1:0];
        high_clear = (value_i[DATA_W-1:MASK_W] == '0);
        filled     = low | (low - MASK_W'(1));
        ext        = {1'b0, filled};
        ok_o       = high_clear && (low != '0) && (((ext + (MASK_W+1)'(1)) & ext) == '0);
    end
endmodule

// File: rtl/cdp_reg_bank.sv
// Register bank: holds the capacity masks and the mode bit. It applies
// accepted writes, builds the combinational read value and flags errors.
// Assumes decode and shape check are provided by sibling blocks.
module cdp_reg_bank #(
    parameter int DATA_W    = 64,
    parameter int NUM_MASKS = 16,
    parameter int MASK_W    = 20,
    localparam int IDX_W    = $clog2(NUM_MASKS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic                               rd_en,
    input  logic                               hit_cfg_i,
    input  logic                               hit_mask_i,
    input  logic [IDX_W-1:0]                   idx_i,
    input  logic                               shape_ok_i,
    input  logic [MASK_W-1:0]                  wmask_i,
    output logic [DATA_W-1:0]                  rdata_o,
    output logic                               err_o,
    output logic [NUM_MASKS-1:0][MASK_W-1:0]   masks_o,
    output logic                               mode_o
);
    logic [NUM_MASKS-1:0][MASK_W-1:0] masks_q;
    logic                             mode_q;
    logic                             unmapped;

    assign unmapped = !hit_cfg_i && !hit_mask_i;

    // State update: reset to full masks, mode off; take legal writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masks_q <= '1;
            mode_q  <= 1'b0;
        end else if (wr_en) begin
            if (hit_cfg_i)
                mode_q <= wmask_i[0];
            else if (hit_mask_i && shape_ok_i)
                masks_q[idx_i] <= wmask_i;
        end
    end

    // Read mux and error flag, both combinational on the current request.
    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            if (hit_cfg_i)
                rdata_o = DATA_W'(mode_q);
            else if (hit_mask_i)
                rdata_o = DATA_W'(masks_q[idx_i]);
        end
        err_o = ((rd_en || wr_en) && unmapped) || (wr_en && hit_mask_i && !shape_ok_i);
    end

    assign masks_o = masks_q;
    assign mode_o  = mode_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (masks_q == {NUM_MASKS{ {MASK_W{1'b1}} }}) && !mode_q);

    assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && err_o) |=> ($stable(masks_q) && $stable(mode_q)));

    assert_unmapped_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |-> (rdata_o == '0 && err_o));

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_mask_i && shape_ok_i) |=> (masks_q[$past(idx_i)] == $past(wmask_i)));

    assert_err_needs_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rd_en || wr_en));

    for (genvar g = 0; g < NUM_MASKS; g++) begin : g_shape
        assert_mask_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            masks_q[g] != '0);
    end
endmodule

// File: rtl/cdp_way_lookup.sv
// Way lookup: picks the mask for a class and access type. In paired mode,
// data uses the even register and code the odd one; classes beyond half the
// bank fall back to class 0. Assumes NUM_MASKS is a power of two, >= 2.
module cdp_way_lookup #(
    parameter int NUM_MASKS = 16,
    parameter int MASK_W    = 20,
    localparam int IDX_W    = $clog2(NUM_MASKS),
    localparam int HALF     = NUM_MASKS / 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_MASKS-1:0][MASK_W-1:0]  masks_i,
    input  logic                              mode_i,
    input  logic [IDX_W-1:0]                  cls_i,
    input  logic                              code_i,
    output logic [MASK_W-1:0]                 mask_o,
    output logic                              bad_o
);
    logic [IDX_W-1:0] sel;
    logic             over;

    // Index selection: direct when unpaired, {class, type} when paired.
    always_comb begin
        over = (cls_i >= IDX_W'(HALF));
        if (!mode_i)
            sel = cls_i;
        else if (over)
            sel = IDX_W'(code_i);
        else
            sel = {cls_i[IDX_W-2:0], code_i};
        bad_o  = mode_i && over;
        mask_o = masks_i[sel];
    end

    assert_bad_needs_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> !bad_o);

    assert_fallback_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_o |-> (mask_o == masks_i[code_i ? 1 : 0]));
endmodule

// File: rtl/cdp_mask_select.sv
// Top: code/data way-mask selector. Joins address decode, write-shape check,
// register bank and lookup. Register reads and lookups are combinational.
module cdp_mask_select #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int NUM_MASKS = 16,
    parameter int MASK_W    = 20,
    localparam int IDX_W    = $clog2(NUM_MASKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    input  logic [IDX_W-1:0]  lk_cls,
    input  logic              lk_code,
    output logic [MASK_W-1:0] lk_mask,
    output logic              lk_bad
);
    logic                             hit_cfg;
    logic                             hit_mask;
    logic [IDX_W-1:0]                 idx;
    logic                             shape_ok;
    logic [NUM_MASKS-1:0][MASK_W-1:0] masks;
    logic                             mode;

    cdp_addr_decode #(.ADDR_W(ADDR_W), .NUM_MASKS(NUM_MASKS)) u_dec (
        .addr_i(addr), .hit_cfg_o(hit_cfg), .hit_mask_o(hit_mask), .idx_o(idx));

    cdp_mask_check #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
        .value_i(wdata), .ok_o(shape_ok));

    cdp_reg_bank #(.DATA_W(DATA_W), .NUM_MASKS(NUM_MASKS), .MASK_W(MASK_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .hit_cfg_i(hit_cfg), .hit_mask_i(hit_mask), .idx_i(idx),
        .shape_ok_i(shape_ok), .wmask_i(wdata[MASK_W-1:0]),
        .rdata_o(rdata), .err_o(err), .masks_o(masks), .mode_o(mode));

    cdp_way_lookup #(.NUM_MASKS(NUM_MASKS), .MASK_W(MASK_W)) u_look (
        .clk(clk), .rst_n(rst_n), .masks_i(masks), .mode_i(mode),
        .cls_i(lk_cls), .code_i(lk_code), .mask_o(lk_mask), .bad_o(lk_bad));
endmodule

// File: tb/cdp_mask_select_bench.sv
// Bench for the way-mask selector: table-driven lookups, then directed tests.
module cdp_mask_select_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        err;
    logic [3:0]  lk_cls = '0;
    logic        lk_code = 1'b0;
    logic [19:0] lk_mask;
    logic        lk_bad;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cdp_mask_select u_cdp_mask_select (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err), .lk_cls(lk_cls),
        .lk_code(lk_code), .lk_mask(lk_mask), .lk_bad(lk_bad));

    // Vector fields: {mode[10], cls[9:6], code[5], exp_idx[4:1], exp_bad[0]}
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 4'd0,  1'b0, 4'd0,  1'b0},
        {1'b0, 4'd5,  1'b0, 4'd5,  1'b0},
        {1'b0, 4'd5,  1'b1, 4'd5,  1'b0},
        {1'b0, 4'd15, 1'b1, 4'd15, 1'b0},
        {1'b1, 4'd0,  1'b0, 4'd0,  1'b0},
        {1'b1, 4'd0,  1'b1, 4'd1,  1'b0},
        {1'b1, 4'd3,  1'b0, 4'd6,  1'b0},
        {1'b1, 4'd3,  1'b1, 4'd7,  1'b0},
        {1'b1, 4'd7,  1'b1, 4'd15, 1'b0},
        {1'b1, 4'd8,  1'b0, 4'd0,  1'b1},
        {1'b1, 4'd15, 1'b1, 4'd1,  1'b1},
        {1'b0, 4'd12, 1'b0, 4'd12, 1'b0}
    };

    function automatic logic [19:0] width_mask(input int idx);
        return 20'((64'd1 << (idx + 1)) - 64'd1);
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [63:0] d, output logic e);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        #1 e = err;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [63:0] d, output logic e);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 begin d = rdata; e = err; end
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog got=%0d exp<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [63:0] d;
        logic e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            rd(32'hC90 + i, d, e);
            check("R1 mask reset", d, 64'hFFFFF);
            check("R10 legal read err", {63'd0, e}, 64'd0);
        end
        rd(32'hC81, d, e);
        check("R1 mode reset", d, 64'd0);

        // R3: program distinct widths, read back
        for (int i = 0; i < 16; i++) begin
            wr(32'hC90 + i, {44'd0, width_mask(i)}, e);
            check("R10 legal write err", {63'd0, e}, 64'd0);
        end
        rd(32'hC93, d, e);
        check("R3 readback", d, 64'hF);

        // R4 R5 R6: vector table
        for (int v = 0; v < NV; v++) begin
            wr(32'hC81, {63'd0, VEC[v][10]}, e);
            @(negedge clk);
            lk_cls = VEC[v][9:6]; lk_code = VEC[v][5];
            #1;
            check(VEC[v][10] ? (VEC[v][0] ? "R6 fallback mask" : "R5 paired mask") : "R4 direct mask",
                  {44'd0, lk_mask}, {44'd0, width_mask(int'(VEC[v][4:1]))});
            check(VEC[v][0] ? "R6 bad flag" : "R4_R5 bad flag", {63'd0, lk_bad}, {63'd0, VEC[v][0]});
        end

        // R2: only bit 0 of config is kept
        wr(32'hC81, 64'hFFFF_FFFF_FFFF_FFFF, e);
        check("R2 cfg write err", {63'd0, e}, 64'd0);
        rd(32'hC81, d, e);
        check("R2 cfg readback", d, 64'd1);
        wr(32'hC81, 64'hFFFF_FFFF_FFFF_FFFE, e);
        rd(32'hC81, d, e);
        check("R2 cfg clear", d, 64'd0);

        // R7: rejected shapes keep old value (mask 4 holds 0x1F)
        wr(32'hC94, 64'd0, e);
        check("R7 zero err", {63'd0, e}, 64'd1);
        wr(32'hC94, 64'h5, e);
        check("R7 gap err", {63'd0, e}, 64'd1);
        wr(32'hC94, 64'h10_0000, e);
        check("R7 high bit err", {63'd0, e}, 64'd1);
        rd(32'hC94, d, e);
        check("R7 kept value", d, 64'h1F);
        wr(32'hC94, 64'hF_FF00, e);
        check("R7 top run ok", {63'd0, e}, 64'd0);
        rd(32'hC94, d, e);
        check("R7 top run stored", d, 64'hFFF00);

        // R8: unmapped addresses
        rd(32'hC80, d, e);
        check("R8 read data", d, 64'd0);
        check("R8 read err", {63'd0, e}, 64'd1);
        rd(32'hCA0, d, e);
        check("R8 past-end err", {63'd0, e}, 64'd1);
        wr(32'hC82, 64'd1, e);
        check("R8 write err", {63'd0, e}, 64'd1);
        wr(32'h1C90, 64'h3, e);
        rd(32'hC81, d, e);
        check("R8 mode unchanged", d, 64'd0);
        rd(32'hC90, d, e);
        check("R8 mask0 unchanged", d, 64'h1);

        // R10: no strobe, no error
        @(negedge clk);
        addr = 32'hDEAD; #1;
        check("R10 idle err", {63'd0, err}, 64'd0);

        // R9: same-cycle write and lookup
        @(negedge clk);
        lk_cls = 4'd2; lk_code = 1'b0;
        addr = 32'hC92; wdata = 64'hF0; wr_en = 1'b1;
        #1 check("R9 old before edge", {44'd0, lk_mask}, 64'h7);
        @(posedge clk);
        #1 check("R9 new after edge", {44'd0, lk_mask}, 64'hF0);
        wr_en = 1'b0;

        // R1: reset again restores state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        #1 check("R1 mask after reset", {44'd0, lk_mask}, 64'hFFFFF);

        finish_run();
    end
endmodule